// File: doc/BRIEF.md
# Linked-Descriptor Transmit Download Engine

This block is the transmit-side bus master of a network controller. It walks a chain of descriptors held in memory. Each descriptor names one buffer fragment. The engine reads that fragment word by word through a simple request/response memory port and pushes the words into a transmit FIFO. Software starts the engine by writing the address of the first descriptor into the list pointer. The engine then follows each descriptor's link until it reads a null link. At that point the list pointer returns to zero, so a zero list pointer also means the engine is idle.

While the engine runs, software can append work to the chain. It issues a stall command and waits until the command-busy flag drops. It then overwrites the null link of the tail descriptor and issues an unstall command. The engine only reads a descriptor's link after that descriptor's data has moved and after any pending stall has been released, so it sees the new link. A descriptor can ask for a completion interrupt. That interrupt stays latched until software acknowledges it with a command. A reset command abandons the current descriptor.

Top module: `dndma_engine`

## Requirements
- R1: After reset the list pointer is zero. The interrupt, command-busy, stalled, memory-request and FIFO-valid outputs are all low.
- R2: While the list pointer is zero, a write of a nonzero address loads that address into the list pointer on the next clock and starts processing there. A write of zero leaves the engine idle and issues no memory request.
- R3: A descriptor at byte address D holds four 32-bit words. D+0 holds the link address, D+4 the control word, D+8 the fragment buffer byte address and D+12 the length word. Length bits 12:0 give a byte count. The engine reads ceil(count/4) consecutive words starting at the buffer address and pushes them to the FIFO in address order. A count of zero pushes nothing.
- R4: When bit 31 of the length word is set, fifo_wlast is high on the final pushed word of that fragment and on no other word. When bit 31 is clear, fifo_wlast stays low for the whole fragment.
- R5: The list pointer holds the address of the descriptor being processed. It moves to the link value after the link is read. After a null link it becomes zero and no further memory request is made.
- R6: A list pointer write while the list pointer is nonzero has no effect.
- R7: Bit 0 of the control word requests an interrupt. dn_irq rises when such a descriptor's data is finished and stays high until an acknowledge command (code 3). A descriptor with bit 0 clear does not raise dn_irq.
- R8: A stall command (code 0) raises cmd_busy until the engine reaches a descriptor boundary. cmd_busy then falls, stalled rises, and no memory request or FIFO push occurs while stalled is high.
- R9: An unstall command (code 1) releases the stall. The engine then reads the current descriptor's link at that moment, so a link rewritten during the stall is followed.
- R10: A reset command (code 2) abandons any descriptor in progress. On the next clock the list pointer is zero and stalled and cmd_busy are low.
- R11: While fifo_wvalid is high and fifo_wready is low, fifo_wvalid stays high and fifo_wdata stays unchanged on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_wr_en | input | 1 | List pointer write strobe |
| lp_wr_data | input | AW | Descriptor address written to the list pointer |
| list_ptr | output | AW | Current descriptor address, zero when idle |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 stall, 1 unstall, 2 reset, 3 acknowledge interrupt |
| cmd_busy | output | 1 | Stall requested but not yet in effect |
| stalled | output | 1 | Engine frozen at a descriptor boundary |
| dn_irq | output | 1 | Latched download-complete interrupt |
| mem_req | output | 1 | Single-cycle word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| fifo_wvalid | output | 1 | FIFO push valid |
| fifo_wready | input | 1 | FIFO can accept a word |
| fifo_wdata | output | 32 | Pushed fragment word |
| fifo_wlast | output | 1 | Final word of a packet's last fragment |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, a 13-bit length field and the interrupt request on control bit 0. Its memory model decodes a 1 KB window, so fragment lengths of a few bytes already exercise partial-word rounding, zero-length descriptors and multi-descriptor chains. The FIFO ready line can be toggled every cycle, which stretches the data phase. Stall, append and reset commands can therefore land in the middle of a fragment rather than only at its edges.

// File: rtl/dndma_pkg.sv
package dndma_pkg;

  typedef enum logic [1:0] {
    CMD_STALL   = 2'd0,
    CMD_UNSTALL = 2'd1,
    CMD_RESET   = 2'd2,
    CMD_ACK     = 2'd3
  } dn_cmd_e;

  typedef enum logic [3:0] {
    W_IDLE, W_HEAD, W_CTL, W_BADR, W_BLEN, W_DRD, W_DWR, W_TAIL, W_LINK
  } walk_st_e;

  localparam int unsigned LAST_BIT = 31;

  // ceil(bytes/4) over the low len_w bits of a length word
  function automatic logic [31:0] frag_words(input logic [31:0] w, input int unsigned len_w);
    logic [31:0] m;
    m = w & ((32'd1 << len_w) - 32'd1);
    return (m + 32'd3) >> 2;
  endfunction

  function automatic logic frag_is_last(input logic [31:0] w);
    return w[LAST_BIT];
  endfunction

endpackage

// File: rtl/dndma_walker.sv
module dndma_walker
  import dndma_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned LEN_W   = 13,
  parameter int unsigned IRQ_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          hold,
  input  logic          lp_wr_en,
  input  logic [AW-1:0] lp_wr_data,
  output logic [AW-1:0] list_ptr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          fifo_wvalid,
  input  logic          fifo_wready,
  output logic [31:0]   fifo_wdata,
  output logic          fifo_wlast,
  output logic          at_safe,
  output logic          desc_done,
  output logic          irq_set,
  output logic          link_null
);
  localparam int unsigned CNT_W = LEN_W - 1;

  walk_st_e        st;
  logic            wait_rsp;
  logic            ctl_irq;
  logic            last_flag;
  logic [AW-1:0]   buf_ptr;
  logic [CNT_W-1:0] words_left;
  logic [31:0]     data_q;
  logic            rsp;
  logic [CNT_W-1:0] len_words;
  logic            fetching;

  assign rsp       = wait_rsp && mem_rvalid;
  assign len_words = CNT_W'(frag_words(mem_rdata, LEN_W));
  assign fetching  = (st == W_CTL) || (st == W_BADR) || (st == W_BLEN) ||
                     (st == W_DRD) || (st == W_LINK);

  always_comb begin
    unique case (st)
      W_CTL:   mem_addr = list_ptr + AW'(4);
      W_BADR:  mem_addr = list_ptr + AW'(8);
      W_BLEN:  mem_addr = list_ptr + AW'(12);
      W_DRD:   mem_addr = buf_ptr;
      default: mem_addr = list_ptr;
    endcase
  end

  assign mem_req     = fetching && !wait_rsp;
  assign fifo_wvalid = (st == W_DWR);
  assign fifo_wdata  = data_q;
  assign fifo_wlast  = (st == W_DWR) && last_flag && (words_left == CNT_W'(1));
  assign at_safe     = (st == W_IDLE) || (st == W_HEAD) || (st == W_TAIL);
  assign desc_done   = ((st == W_BLEN) && rsp && (len_words == '0)) ||
                       ((st == W_DWR) && fifo_wready && (words_left == CNT_W'(1)));
  assign irq_set     = desc_done && ctl_irq;
  assign link_null   = (st == W_LINK) && rsp && (mem_rdata[AW-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= W_IDLE;
      wait_rsp   <= 1'b0;
      list_ptr   <= '0;
      ctl_irq    <= 1'b0;
      last_flag  <= 1'b0;
      buf_ptr    <= '0;
      words_left <= '0;
      data_q     <= '0;
    end else if (flush) begin
      st       <= W_IDLE;
      wait_rsp <= 1'b0;
      list_ptr <= '0;
    end else begin
      if (mem_req) wait_rsp <= 1'b1;
      if (rsp)     wait_rsp <= 1'b0;
      unique case (st)
        W_IDLE: if (lp_wr_en && lp_wr_data != '0) begin
          list_ptr <= lp_wr_data;
          st       <= W_HEAD;
        end
        W_HEAD: if (!hold) st <= W_CTL;
        W_CTL: if (rsp) begin
          ctl_irq <= mem_rdata[IRQ_BIT];
          st      <= W_BADR;
        end
        W_BADR: if (rsp) begin
          buf_ptr <= mem_rdata[AW-1:0];
          st      <= W_BLEN;
        end
        W_BLEN: if (rsp) begin
          words_left <= len_words;
          last_flag  <= frag_is_last(mem_rdata);
          st         <= (len_words == '0) ? W_TAIL : W_DRD;
        end
        W_DRD: if (rsp) begin
          data_q <= mem_rdata;
          st     <= W_DWR;
        end
        W_DWR: if (fifo_wready) begin
          buf_ptr    <= buf_ptr + AW'(4);
          words_left <= words_left - CNT_W'(1);
          st         <= (words_left == CNT_W'(1)) ? W_TAIL : W_DRD;
        end
        W_TAIL: if (!hold) st <= W_LINK;
        W_LINK: if (rsp) begin
          list_ptr <= mem_rdata[AW-1:0];
          st       <= (mem_rdata[AW-1:0] == '0) ? W_IDLE : W_HEAD;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dndma_ctl.sv
module dndma_ctl
  import dndma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       at_safe,
  input  logic       irq_set,
  output logic       flush,
  output logic       hold,
  output logic       cmd_busy,
  output logic       stalled,
  output logic       dn_irq
);
  logic stall_pend;
  logic is_stall, is_unstall, is_ack;

  assign is_stall   = cmd_valid && (dn_cmd_e'(cmd_code) == CMD_STALL);
  assign is_unstall = cmd_valid && (dn_cmd_e'(cmd_code) == CMD_UNSTALL);
  assign is_ack     = cmd_valid && (dn_cmd_e'(cmd_code) == CMD_ACK);
  assign flush      = cmd_valid && (dn_cmd_e'(cmd_code) == CMD_RESET);

  assign hold     = stall_pend;
  assign stalled  = stall_pend && at_safe;
  assign cmd_busy = stall_pend && !at_safe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_pend <= 1'b0;
      dn_irq     <= 1'b0;
    end else begin
      if (is_stall)               stall_pend <= 1'b1;
      if (is_unstall || flush)    stall_pend <= 1'b0;
      if (irq_set)                dn_irq     <= 1'b1;
      else if (is_ack)            dn_irq     <= 1'b0;
    end
  end
endmodule

// File: rtl/dndma_engine.sv
module dndma_engine
  import dndma_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned LEN_W   = 13,
  parameter int unsigned IRQ_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_wr_en,
  input  logic [AW-1:0] lp_wr_data,
  output logic [AW-1:0] list_ptr,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  output logic          cmd_busy,
  output logic          stalled,
  output logic          dn_irq,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          fifo_wvalid,
  input  logic          fifo_wready,
  output logic [31:0]   fifo_wdata,
  output logic          fifo_wlast
);
  logic flush, hold, at_safe, desc_done, irq_set, link_null;

  dndma_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .at_safe(at_safe), .irq_set(irq_set), .flush(flush), .hold(hold),
    .cmd_busy(cmd_busy), .stalled(stalled), .dn_irq(dn_irq)
  );

  dndma_walker #(.AW(AW), .LEN_W(LEN_W), .IRQ_BIT(IRQ_BIT)) u_walk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .hold(hold),
    .lp_wr_en(lp_wr_en), .lp_wr_data(lp_wr_data), .list_ptr(list_ptr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .fifo_wvalid(fifo_wvalid), .fifo_wready(fifo_wready),
    .fifo_wdata(fifo_wdata), .fifo_wlast(fifo_wlast), .at_safe(at_safe),
    .desc_done(desc_done), .irq_set(irq_set), .link_null(link_null)
  );
endmodule

// File: rtl/dndma_engine_chk.sv
module dndma_engine_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] list_ptr,
  input logic          cmd_valid,
  input logic [1:0]    cmd_code,
  input logic          cmd_busy,
  input logic          stalled,
  input logic          dn_irq,
  input logic          mem_req,
  input logic          fifo_wvalid,
  input logic          fifo_wready,
  input logic [31:0]   fifo_wdata,
  input logic          link_null
);
  logic rst_cmd, ack_cmd;
  assign rst_cmd = cmd_valid && cmd_code == 2'd2;
  assign ack_cmd = cmd_valid && cmd_code == 2'd3;

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (list_ptr == '0) |-> !mem_req && !fifo_wvalid);                  // R5
  AST_NULL_LINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (link_null && !cmd_valid) |=> (list_ptr == '0));                 // R5
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !mem_req && !fifo_wvalid);                           // R8
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_busy && stalled));                                          // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_irq && !ack_cmd) |=> dn_irq);                                 // R7
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (list_ptr == '0) && !stalled && !cmd_busy);           // R10
  AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wvalid && !fifo_wready && !rst_cmd) |=> fifo_wvalid && $stable(fifo_wdata)); // R11
endmodule

bind dndma_engine dndma_engine_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .list_ptr(list_ptr), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .cmd_busy(cmd_busy), .stalled(stalled), .dn_irq(dn_irq),
  .mem_req(mem_req), .fifo_wvalid(fifo_wvalid), .fifo_wready(fifo_wready),
  .fifo_wdata(fifo_wdata), .link_null(link_null)
);

// File: tb/dndma_engine_tb.sv
module dndma_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_wr_en = 1'b0;
  logic [AW-1:0] lp_wr_data = '0;
  logic [AW-1:0] list_ptr;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic cmd_busy, stalled, dn_irq, mem_req, fifo_wvalid, fifo_wlast;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic fifo_wready;
  logic [31:0] fifo_wdata;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:255];
  logic [31:0] cap_d [0:63];
  logic cap_l [0:63];
  int cap_n = 0;
  int req_n = 0;
  logic bp_en = 1'b0;
  logic bp_tgl = 1'b0;
  logic seen_140 = 1'b0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dndma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .lp_wr_en(lp_wr_en), .lp_wr_data(lp_wr_data),
    .list_ptr(list_ptr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_busy(cmd_busy), .stalled(stalled), .dn_irq(dn_irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .fifo_wvalid(fifo_wvalid), .fifo_wready(fifo_wready),
    .fifo_wdata(fifo_wdata), .fifo_wlast(fifo_wlast)
  );

  assign fifo_wready = bp_en ? bp_tgl : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= mem_req;
    if (mem_req) begin
      mem_rdata <= mem[mem_addr[9:2]];
      req_n <= req_n + 1;
    end
    if (fifo_wvalid && fifo_wready && cap_n < 64) begin
      cap_d[cap_n] <= fifo_wdata;
      cap_l[cap_n] <= fifo_wlast;
      cap_n <= cap_n + 1;
    end
    if (list_ptr == 32'h140) seen_140 <= 1'b1;
  end
  always @(negedge clk) bp_tgl <= ~bp_tgl;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_lp(input logic [31:0] a);
    @(negedge clk); lp_wr_en = 1'b1; lp_wr_data = a;
    @(negedge clk); lp_wr_en = 1'b0; lp_wr_data = '0;
  endtask

  task automatic send_cmd(input logic [1:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && list_ptr != '0; i++) @(negedge clk);
  endtask

  task automatic put_desc(input int a, input logic [31:0] nxt, input logic [31:0] ctl,
                          input logic [31:0] badr, input logic [31:0] len);
    mem[a/4] = nxt; mem[a/4+1] = ctl; mem[a/4+2] = badr; mem[a/4+3] = len;
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i;
  endtask

  task automatic t_reset();
    chk("R1 list_ptr", list_ptr, 0);
    chk("R1 irq/busy/stall", {dn_irq, cmd_busy, stalled}, 0);
    chk("R1 req/valid", {mem_req, fifo_wvalid}, 0);
  endtask

  task automatic t_single();
    fill(); cap_n = 0;
    put_desc(32'h100, 0, 32'h1, 32'h200, 32'h8000_000A);
    write_lp(32'h100);
    chk("R2 start ptr", list_ptr, 32'h100);
    wait_idle(); repeat (2) @(negedge clk);
    chk("R3 word count", cap_n, 3);
    chk("R3 word0", cap_d[0], 32'hA500_0080);
    chk("R3 word2", cap_d[2], 32'hA500_0082);
    chk("R4 last flags", {cap_l[0], cap_l[1], cap_l[2]}, 3'b001);
    chk("R5 ptr zero", list_ptr, 0);
    chk("R7 irq set", dn_irq, 1);
    send_cmd(2'd3);
    chk("R7 irq ack", dn_irq, 0);
  endtask

  task automatic t_zero_write();
    int r0;
    r0 = req_n;
    write_lp(0);
    repeat (5) @(negedge clk);
    chk("R2 zero write idle", list_ptr, 0);
    chk("R2 zero write no req", req_n - r0, 0);
  endtask

  task automatic t_chain();
    fill(); cap_n = 0; bp_en = 1'b1; seen_140 = 1'b0;
    put_desc(32'h100, 32'h140, 0, 32'h200, 32'd8);
    put_desc(32'h140, 0, 0, 32'h300, 32'h8000_0005);
    write_lp(32'h100);
    wait_idle(); repeat (2) @(negedge clk);
    bp_en = 1'b0;
    chk("R3 chain count", cap_n, 4);
    chk("R11 chain order", {cap_d[1][7:0], cap_d[2][7:0], cap_d[3][7:0]}, 24'h81_C0_C1);
    chk("R4 chain last", {cap_l[0], cap_l[1], cap_l[2], cap_l[3]}, 4'b0001);
    chk("R5 saw second", seen_140, 1);
    chk("R7 no irq", dn_irq, 0);
  endtask

  task automatic t_busy_write();
    fill(); cap_n = 0; bp_en = 1'b1;
    put_desc(32'h100, 0, 0, 32'h200, 32'd64);
    put_desc(32'h140, 0, 0, 32'h300, 32'd4);
    write_lp(32'h100);
    repeat (6) @(negedge clk);
    write_lp(32'h140);
    chk("R6 ptr unchanged", list_ptr, 32'h100);
    wait_idle(); repeat (2) @(negedge clk);
    bp_en = 1'b0;
    chk("R6 count", cap_n, 16);
    chk("R6 first word", cap_d[0], 32'hA500_0080);
  endtask

  task automatic t_stall_append();
    int c0;
    fill(); cap_n = 0; bp_en = 1'b1;
    put_desc(32'h100, 0, 0, 32'h200, 32'd40);
    put_desc(32'h140, 0, 0, 32'h300, 32'h8000_0004);
    write_lp(32'h100);
    repeat (8) @(negedge clk);
    send_cmd(2'd0);
    chk("R8 busy pending", {cmd_busy, stalled}, 2'b10);
    for (int i = 0; i < 500 && !stalled; i++) @(negedge clk);
    chk("R8 stalled", {cmd_busy, stalled}, 2'b01);
    chk("R8 ptr at boundary", list_ptr, 32'h100);
    mem[32'h100/4] = 32'h140;
    c0 = cap_n;
    repeat (10) @(negedge clk);
    chk("R8 frozen", cap_n - c0, 0);
    send_cmd(2'd1);
    wait_idle(); repeat (2) @(negedge clk);
    bp_en = 1'b0;
    chk("R9 appended count", cap_n, 11);
    chk("R9 appended word", cap_d[10], 32'hA500_00C0);
    chk("R9 appended last", cap_l[10], 1);
  endtask

  task automatic t_reset_cmd();
    int c0;
    fill(); cap_n = 0; bp_en = 1'b1;
    put_desc(32'h100, 0, 32'h1, 32'h200, 32'd64);
    write_lp(32'h100);
    repeat (6) @(negedge clk);
    send_cmd(2'd0);
    send_cmd(2'd2);
    chk("R10 ptr cleared", list_ptr, 0);
    chk("R10 stall cleared", {cmd_busy, stalled}, 0);
    c0 = cap_n;
    repeat (6) @(negedge clk);
    chk("R10 no pushes", cap_n - c0, 0);
    bp_en = 1'b0;
    chk("R7 no irq after drop", dn_irq, 0);
  endtask

  task automatic t_zero_len();
    fill(); cap_n = 0;
    put_desc(32'h100, 0, 32'h1, 32'h200, 32'h8000_0000);
    write_lp(32'h100);
    wait_idle(); repeat (2) @(negedge clk);
    chk("R3 zero length pushes", cap_n, 0);
    chk("R7 zero length irq", dn_irq, 1);
    send_cmd(2'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_zero_write();
    t_chain();
    t_busy_write();
    t_stall_append();
    t_reset_cmd();
    t_zero_len();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule